// File: doc/BRIEF.md
# Sliced Data Readback Holding Logic

This block sits between a video line data slicer and a host register port. The slicer hands it finished payload words for four classes of auxiliary line data: closed caption, copy-protection/wide-screen signalling, the program-delivery/timecode class and vertical-interval timecode. The block copies each accepted word into a readback register that the host reads over a simple byte-wide port. For every accepted word it also raises a one-cycle event that an interrupt controller can latch.

Closed-caption data is protected by a handshake. Once a caption word is captured, an available flag rises and the word is frozen. Later caption words are dropped until the host writes a read-done bit. The copy-protection class fires its event only when the captured payload differs from the previous one. The program-delivery class has a host-selectable mode: it fires on every capture or only on a change. Timecode fires on every capture.

Top module: `sliced_hold`

## Requirements
- R1: After reset the closed-caption available flag is 0, all four event outputs are 0, and every readback byte reads 0.
- R2: A closed-caption word presented while the available flag is 0 is stored. On the clock edge that samples it, `cc_avail` goes to 1, and `evt_cc` is high for the cycle that follows.
- R3: While `cc_avail` is 1, presented closed-caption words are discarded: the held word is unchanged and no `evt_cc` pulse is produced.
- R4: Writing a byte with bit 0 set to address 0x78 clears `cc_avail`. The held word is kept, and the next closed-caption word may then be captured. Reads of 0x78 return 0 in bit 0 and `cc_avail` in bit 1, with the other bits 0.
- R5: If a read-done write and a closed-caption word arrive in the same cycle while `cc_avail` is 1, the word is discarded, no event fires and `cc_avail` ends at 0.
- R6: Every presented copy-protection word is stored. `evt_cg` pulses only when the word differs from the previously stored one, and the first word after reset always counts as different.
- R7: Address 0x70 bit 0 is a read/write mode bit for the program-delivery class. With 0, `evt_pd` pulses on every capture. With 1, it pulses only when the word differs from the last stored one, the first word after reset counting as different. The comparison always uses the last stored word, whichever mode was active when it was stored.
- R8: Every presented timecode word is stored, and `evt_vt` pulses for each one, including repeats of the same value.
- R9: Readback bytes are little-endian within windows: closed caption at 0x00, copy-protection at 0x08, program-delivery at 0x10, timecode at 0x18. Bytes beyond a payload's width and unmapped addresses read 0. Reads are combinational.
- R10: A single-cycle valid produces an event that is high for exactly one clock cycle and low in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cc_vld | input | 1 | Closed-caption word valid |
| cc_word | input | CC_W | Closed-caption payload |
| cg_vld | input | 1 | Copy-protection word valid |
| cg_word | input | CG_W | Copy-protection payload |
| pd_vld | input | 1 | Program-delivery word valid |
| pd_word | input | PD_W | Program-delivery payload |
| vt_vld | input | 1 | Timecode word valid |
| vt_word | input | VT_W | Timecode payload |
| reg_addr | input | 8 | Host byte address |
| reg_we | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| cc_avail | output | 1 | Closed-caption data held and unread |
| evt_cc | output | 1 | Closed-caption capture event |
| evt_cg | output | 1 | Copy-protection change event |
| evt_pd | output | 1 | Program-delivery event |
| evt_vt | output | 1 | Timecode capture event |

## Verification
A stuck or wrongly set lock flag shows up within one capture. Either a caption word that should have been dropped overwrites the readback bytes and fires `evt_cc`, or a word that should be taken after read-done produces no event. Corrupted or missing last-word storage for the change-detecting classes shows as a missing or extra `evt_cg`/`evt_pd` pulse one cycle after a repeated or altered word. A wrong mode bit shows at the next program-delivery repeat. Readback byte order errors appear on the first read of a multi-byte window.

// File: rtl/sliced_hold.sv
module sliced_hold #(
  parameter int CC_W = 16,
  parameter int CG_W = 20,
  parameter int PD_W = 32,
  parameter int VT_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cc_vld,
  input  logic [CC_W-1:0] cc_word,
  input  logic            cg_vld,
  input  logic [CG_W-1:0] cg_word,
  input  logic            pd_vld,
  input  logic [PD_W-1:0] pd_word,
  input  logic            vt_vld,
  input  logic [VT_W-1:0] vt_word,
  input  logic [7:0]      reg_addr,
  input  logic            reg_we,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            cc_avail,
  output logic            evt_cc,
  output logic            evt_cg,
  output logic            evt_pd,
  output logic            evt_vt
);
  localparam logic [7:0] MODE_ADDR = 8'h70;
  localparam logic [7:0] CTRL_ADDR = 8'h78;

  logic [CC_W-1:0] cc_rb;
  logic [CG_W-1:0] cg_rb;
  logic [PD_W-1:0] pd_rb;
  logic [VT_W-1:0] vt_rb;
  logic            cg_seen, pd_seen, chg_mode;
  logic [63:0]     win;

  wire done_wr = reg_we && reg_addr == CTRL_ADDR && reg_wdata[0];
  wire mode_wr = reg_we && reg_addr == MODE_ADDR;
  wire cc_take = cc_vld && !cc_avail;
  wire cg_diff = !cg_seen || cg_word != cg_rb;
  wire pd_diff = !pd_seen || pd_word != pd_rb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_rb    <= '0;
      cg_rb    <= '0;
      pd_rb    <= '0;
      vt_rb    <= '0;
      cg_seen  <= 1'b0;
      pd_seen  <= 1'b0;
      chg_mode <= 1'b0;
      cc_avail <= 1'b0;
      evt_cc   <= 1'b0;
      evt_cg   <= 1'b0;
      evt_pd   <= 1'b0;
      evt_vt   <= 1'b0;
    end else begin
      evt_cc <= cc_take;
      evt_cg <= cg_vld && cg_diff;
      evt_pd <= pd_vld && (!chg_mode || pd_diff);
      evt_vt <= vt_vld;
      if (cc_take) begin
        cc_rb    <= cc_word;
        cc_avail <= 1'b1;
      end else if (done_wr) begin
        cc_avail <= 1'b0;
      end
      if (cg_vld) begin
        cg_rb   <= cg_word;
        cg_seen <= 1'b1;
      end
      if (pd_vld) begin
        pd_rb   <= pd_word;
        pd_seen <= 1'b1;
      end
      if (vt_vld) vt_rb <= vt_word;
      if (mode_wr) chg_mode <= reg_wdata[0];
    end
  end

  always_comb begin
    case (reg_addr[7:3])
      5'd0:    win = 64'(cc_rb);
      5'd1:    win = 64'(cg_rb);
      5'd2:    win = 64'(pd_rb);
      5'd3:    win = 64'(vt_rb);
      default: win = '0;
    endcase
    if (reg_addr == MODE_ADDR)      reg_rdata = {7'b0, chg_mode};
    else if (reg_addr == CTRL_ADDR) reg_rdata = {6'b0, cc_avail, 1'b0};
    else                            reg_rdata = win[{reg_addr[2:0], 3'b000} +: 8];
  end
endmodule

module sliced_hold_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cc_vld,
  input logic       cg_vld,
  input logic       pd_vld,
  input logic       vt_vld,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       cc_avail,
  input logic       chg_mode,
  input logic       evt_cc,
  input logic       evt_cg,
  input logic       evt_pd,
  input logic       evt_vt
);
  wire done_w = reg_we && reg_addr == 8'h78 && reg_wdata[0];

  // R2
  cc_evt_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cc |-> cc_avail);
  // R3
  cc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_avail && !done_w) |=> (cc_avail && !evt_cc));
  // R4
  cc_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_avail && done_w) |=> !cc_avail);
  // R6
  cg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_vld |=> !evt_cg);
  // R7
  pd_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_vld && !chg_mode) |=> evt_pd);
  // R8
  vt_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vt_vld |=> evt_vt);
  // R10
  vt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vt_vld |=> !evt_vt);
endmodule

bind sliced_hold sliced_hold_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cc_vld(cc_vld), .cg_vld(cg_vld), .pd_vld(pd_vld),
  .vt_vld(vt_vld), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .cc_avail(cc_avail), .chg_mode(chg_mode), .evt_cc(evt_cc), .evt_cg(evt_cg),
  .evt_pd(evt_pd), .evt_vt(evt_vt)
);

// File: tb/tb_sliced_hold.sv
module tb_sliced_hold;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cc_vld = 0, cg_vld = 0, pd_vld = 0, vt_vld = 0;
  logic [15:0] cc_word = '0;
  logic [19:0] cg_word = '0;
  logic [31:0] pd_word = '0;
  logic [63:0] vt_word = '0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic        reg_we = 1'b0;
  logic        cc_avail, evt_cc, evt_cg, evt_pd, evt_vt;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  sliced_hold dut (
    .clk(clk), .rst_n(rst_n), .cc_vld(cc_vld), .cc_word(cc_word), .cg_vld(cg_vld),
    .cg_word(cg_word), .pd_vld(pd_vld), .pd_word(pd_word), .vt_vld(vt_vld),
    .vt_word(vt_word), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cc_avail(cc_avail), .evt_cc(evt_cc), .evt_cg(evt_cg),
    .evt_pd(evt_pd), .evt_vt(evt_vt)
  );

  // [39] program-delivery class (else copy-protection), [38] mode bit, [37] expected event, [31:0] word
  localparam logic [39:0] VEC [0:9] = '{
    {1'b0, 1'b0, 1'b1, 5'd0, 32'h0001_2345},
    {1'b0, 1'b0, 1'b0, 5'd0, 32'h0001_2345},
    {1'b0, 1'b0, 1'b1, 5'd0, 32'h0001_2346},
    {1'b0, 1'b0, 1'b0, 5'd0, 32'h0001_2346},
    {1'b1, 1'b0, 1'b1, 5'd0, 32'h0000_000A},
    {1'b1, 1'b0, 1'b1, 5'd0, 32'h0000_000A},
    {1'b1, 1'b1, 1'b0, 5'd0, 32'h0000_000A},
    {1'b1, 1'b1, 1'b1, 5'd0, 32'h0000_000B},
    {1'b1, 1'b1, 1'b0, 5'd0, 32'h0000_000B},
    {1'b1, 1'b0, 1'b1, 5'd0, 32'h0000_000B}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cc_avail", cc_avail, 0);
    chk("R1 events", {evt_cc, evt_cg, evt_pd, evt_vt}, 0);
    rd(8'h00, d); chk("R1 cc byte", d, 0);
    rd(8'h13, d); chk("R1 pd byte", d, 0);
    rd(8'h78, d); chk("R1 ctrl", d, 0);

    // R6 R7 table walk
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][39]) wr(8'h70, {7'b0, VEC[i][38]});
      @(negedge clk);
      if (VEC[i][39]) begin pd_vld = 1; pd_word = VEC[i][31:0]; end
      else begin cg_vld = 1; cg_word = VEC[i][19:0]; end
      @(negedge clk);
      pd_vld = 0; cg_vld = 0;
      if (VEC[i][39]) chk("R7 pd event", evt_pd, VEC[i][37]);
      else            chk("R6 cg event", evt_cg, VEC[i][37]);
      rd(VEC[i][39] ? 8'h10 : 8'h08, d);
      chk(VEC[i][39] ? "R7 pd stored" : "R6 cg stored", d, VEC[i][7:0]);
    end
    rd(8'h70, d); chk("R7 mode readback", d, 0);
    rd(8'h0A, d); chk("R9 cg top byte", d, 8'h01);
    rd(8'h0B, d); chk("R9 cg pad byte", d, 0);

    // R2 capture
    @(negedge clk); cc_vld = 1; cc_word = 16'hBEEF;
    @(negedge clk); cc_vld = 0;
    chk("R2 evt_cc", evt_cc, 1);
    chk("R2 cc_avail", cc_avail, 1);
    rd(8'h00, d); chk("R9 cc low", d, 8'hEF);
    rd(8'h01, d); chk("R9 cc high", d, 8'hBE);
    rd(8'h78, d); chk("R4 ctrl shows avail", d, 8'h02);
    @(negedge clk);
    chk("R10 evt_cc one cycle", evt_cc, 0);

    // R3 locked discard
    cc_vld = 1; cc_word = 16'h1234;
    @(negedge clk); cc_vld = 0;
    chk("R3 no event", evt_cc, 0);
    rd(8'h00, d); chk("R3 held", d, 8'hEF);

    // R4 read-done
    wr(8'h78, 8'h01);
    chk("R4 avail cleared", cc_avail, 0);
    rd(8'h78, d); chk("R4 ctrl reads 0", d, 0);
    rd(8'h01, d); chk("R4 data kept", d, 8'hBE);
    @(negedge clk); cc_vld = 1; cc_word = 16'h5555;
    @(negedge clk); cc_vld = 0;
    chk("R4 recapture evt", evt_cc, 1);
    rd(8'h00, d); chk("R4 recaptured", d, 8'h55);

    // R5 same-cycle done and capture
    @(negedge clk);
    cc_vld = 1; cc_word = 16'h7777;
    reg_we = 1; reg_addr = 8'h78; reg_wdata = 8'h01;
    @(negedge clk);
    cc_vld = 0; reg_we = 0;
    chk("R5 no event", evt_cc, 0);
    chk("R5 avail cleared", cc_avail, 0);
    rd(8'h00, d); chk("R5 data kept", d, 8'h55);

    // R8 timecode repeats
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); vt_vld = 1; vt_word = 64'hA1B2_C3D4_E5F6_0718;
      @(negedge clk); vt_vld = 0;
      chk("R8 evt_vt", evt_vt, 1);
    end
    @(negedge clk);
    chk("R10 evt_vt low", evt_vt, 0);
    rd(8'h1F, d); chk("R9 vt top byte", d, 8'hA1);
    rd(8'h18, d); chk("R8 vt low byte", d, 8'h18);
    rd(8'h40, d); chk("R9 unmapped", d, 0);

    done = 1;
    summary();
  end
endmodule